// File: doc/BRIEF.md
# Sliding-Window Codeword Expander

This block turns a stream of compressed codewords back into the original symbol stream. Each codeword is either a literal, which carries one symbol, or a back-reference, which names a position in the recent output history and a run length. The history is a chain of registers holding the most recent output symbols. Every emitted symbol, whether it came straight from a literal or was copied out of the chain, is pushed onto the head of the chain.

A back-reference is expanded one symbol per clock. On each cycle a multiplexer picks the chain stage named by the captured pointer. That stage value goes out and is also pushed back into the chain. The pointer stays fixed for the whole run, so a run longer than its distance repeats the symbols it has just produced. The input side uses a valid/ready handshake and refuses new codewords while a run is still being expanded. The output is a symbol with a valid strobe and has no backpressure.

Top module: `lzss_window_decomp`

## Requirements
- R1: After reset `out_valid` is 0, `cw_ready` is 1 and every history stage holds 0, so a back-reference issued before any output yields zero symbols.
- R2: Bit 8 of the 9-bit codeword is the kind flag, where 0 means literal and 1 means back-reference. A literal carries its symbol in bits 7:0. A back-reference carries the pointer in bits 6:3 and the length field in bits 2:0. Bit 7 of a back-reference is ignored.
- R3: A literal accepted on a clock edge appears on `out_sym` with `out_valid` high in the cycle after that edge, unchanged, and becomes the newest history entry.
- R4: A back-reference with length field k produces k+1 symbols on consecutive cycles. The first appears in the cycle after the accepting edge.
- R5: Pointer value p selects the symbol that was emitted p+1 symbols before the one now being produced, with p = 0 meaning the newest. The pointer is held for the whole run, so copied symbols feed later ones in the same run.
- R6: After a back-reference with length field k is accepted, `cw_ready` stays low for exactly k cycles. It rises in the cycle that shows the last symbol of the run.
- R7: A codeword presented with `cw_valid` high while `cw_ready` is low is not taken and has no effect on the output stream.
- R8: The history keeps exactly the 16 most recent symbols, and pointer 15 reaches the oldest of them.
- R9: No symbol is emitted in a cycle that follows an edge where no codeword was accepted and no run was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Codeword on `cw_data` is offered |
| cw_ready | output | 1 | Block can take a codeword this cycle |
| cw_data | input | 9 | Codeword: flag, then literal or pointer/length fields |
| out_valid | output | 1 | `out_sym` carries a reconstructed symbol |
| out_sym | output | 8 | Reconstructed symbol |

## Verification
The assertions take for granted that the consumer takes a symbol on every cycle that `out_valid` is high, because the block has no output stall. They also assume that the producer of codewords started from the same all-zero history, so pointers into unwritten stages are meant to read zero. The stimulus keeps to these assumptions by sampling every output at the falling edge and by checking against a model history that is seeded with sixteen zeros. It presents codewords only through the handshake and sometimes holds stale or junk words valid while `cw_ready` is low, which exercises the refusal path without leaving the protocol.

// File: rtl/lzss_dec_pkg.sv
package lzss_dec_pkg;

    localparam int SYM_W     = 8;
    localparam int WIN_DEPTH = 16;
    localparam int MAX_COPY  = 8;

    localparam int PTR_W   = $clog2(WIN_DEPTH);
    localparam int LEN_W   = $clog2(MAX_COPY);
    localparam int REF_W   = PTR_W + LEN_W;
    localparam int FIELD_W = (SYM_W > REF_W) ? SYM_W : REF_W;
    localparam int CW_W    = FIELD_W + 1;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [LEN_W-1:0] len_t;
    typedef logic [CW_W-1:0]  cw_t;

    typedef enum logic {
        CW_LIT   = 1'b0,
        CW_MATCH = 1'b1
    } cw_kind_e;

    typedef struct packed {
        cw_kind_e kind;
        sym_t     lit;
        ptr_t     ptr;
        len_t     len;
    } cw_fields_t;

    function automatic cw_fields_t split_cw(cw_t cw);
        cw_fields_t f;
        f.kind = cw_kind_e'(cw[CW_W-1]);
        f.lit  = cw[SYM_W-1:0];
        f.ptr  = cw[REF_W-1:LEN_W];
        f.len  = cw[LEN_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/lzss_code_check.sv
module lzss_code_check
    import lzss_dec_pkg::*;
(
    input  cw_t        cw,
    output cw_fields_t fields
);
    // The flag routes the payload to the literal path or to pointer/length.
    always_comb begin
        fields = split_cw(cw);
    end
endmodule

// File: rtl/lzss_history_window.sv
module lzss_history_window
    import lzss_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  sym_t sym_in,
    input  ptr_t sel,
    output sym_t tap
);
    sym_t stage [WIN_DEPTH];

    genvar g;
    generate
        for (g = 0; g < WIN_DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)           stage[g] <= '0;
                    else if (shift_en) stage[g] <= sym_in;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)           stage[g] <= '0;
                    else if (shift_en) stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    // Pointer-driven selection of one stage.
    assign tap = stage[sel];

    // R3
    window_load_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stage[0] == $past(sym_in));

    // R8
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stage[WIN_DEPTH-1]));
endmodule

// File: rtl/lzss_copy_ctrl.sv
module lzss_copy_ctrl
    import lzss_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  ptr_t ptr_in,
    input  len_t len_in,
    output logic busy,
    output ptr_t ptr_sel
);
    len_t remain_q;
    ptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            ptr_q    <= '0;
        end else if (start) begin
            remain_q <= len_in;
            ptr_q    <= ptr_in;
        end else if (busy) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy    = (remain_q != '0);
    assign ptr_sel = busy ? ptr_q : ptr_in;

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (ptr_q == $past(ptr_q)));

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (remain_q == len_t'($past(remain_q) - 1'b1)));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/lzss_window_decomp.sv
module lzss_window_decomp
    import lzss_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cw_valid,
    output logic            cw_ready,
    input  logic [CW_W-1:0] cw_data,
    output logic            out_valid,
    output logic [SYM_W-1:0] out_sym
);
    cw_fields_t fields;
    logic       accept, lit_go, match_go, busy, shift_en;
    ptr_t       ptr_sel;
    sym_t       tap, next_sym;
    logic       out_valid_q;
    sym_t       out_sym_q;

    lzss_code_check u_check (
        .cw     (cw_data),
        .fields (fields)
    );

    assign accept   = cw_valid && cw_ready;
    assign lit_go   = accept && (fields.kind == CW_LIT);
    assign match_go = accept && (fields.kind == CW_MATCH);

    lzss_copy_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (match_go),
        .ptr_in  (fields.ptr),
        .len_in  (fields.len),
        .busy    (busy),
        .ptr_sel (ptr_sel)
    );

    assign shift_en = lit_go || match_go || busy;
    assign next_sym = lit_go ? fields.lit : tap;

    lzss_history_window u_win (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .sym_in   (next_sym),
        .sel      (ptr_sel),
        .tap      (tap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_sym_q   <= '0;
        end else begin
            out_valid_q <= shift_en;
            if (shift_en) out_sym_q <= next_sym;
        end
    end

    assign cw_ready  = !busy;
    assign out_valid = out_valid_q;
    assign out_sym   = out_sym_q;

    // R3
    lit_out_chk: assert property (@(posedge clk) disable iff (rst)
        lit_go |=> (out_valid && out_sym == $past(cw_data[SYM_W-1:0])));

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (match_go && cw_data[LEN_W-1:0] != '0) |=> !cw_ready);

    // R4
    copy_stream_chk: assert property (@(posedge clk) disable iff (rst)
        !cw_ready |=> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cw_valid && cw_ready) |=> !out_valid);
endmodule

// File: tb/lzss_window_decomp_tb.sv
module lzss_window_decomp_tb;
    import lzss_dec_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst;
    logic            cw_valid;
    logic            cw_ready;
    logic [CW_W-1:0] cw_data;
    logic            out_valid;
    logic [SYM_W-1:0] out_sym;

    int checks = 0;
    int fails  = 0;

    logic [SYM_W-1:0] exp_q[$];
    string            tag_q[$];
    logic [SYM_W-1:0] hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lzss_window_decomp u_dut (
        .clk       (clk),
        .rst       (rst),
        .cw_valid  (cw_valid),
        .cw_ready  (cw_ready),
        .cw_data   (cw_data),
        .out_valid (out_valid),
        .out_sym   (out_sym)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a symbol appears.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected symbol", int'(out_sym), 0);
            end else begin
                logic [SYM_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_sym == e, t, int'(out_sym), int'(e));
            end
        end
    end

    function automatic logic [CW_W-1:0] mk_lit(input logic [SYM_W-1:0] s);
        return {1'b0, s};
    endfunction

    function automatic logic [CW_W-1:0] mk_ref(input int p, input int k);
        logic [CW_W-1:0] w;
        w = '0;
        w[CW_W-1]        = 1'b1;
        w[REF_W-1:LEN_W] = PTR_W'(p);
        w[LEN_W-1:0]     = LEN_W'(k);
        return w;
    endfunction

    task automatic model(input logic [CW_W-1:0] w, input string tag);
        if (!w[CW_W-1]) begin
            exp_q.push_back(w[SYM_W-1:0]);
            tag_q.push_back(tag);
            hist.push_back(w[SYM_W-1:0]);
        end else begin
            int p, k;
            p = int'(w[REF_W-1:LEN_W]);
            k = int'(w[LEN_W-1:0]);
            for (int i = 0; i <= k; i++) begin
                logic [SYM_W-1:0] s;
                s = hist[hist.size()-1-p];
                exp_q.push_back(s);
                tag_q.push_back(tag);
                hist.push_back(s);
            end
        end
    endtask

    // Driver: called at a falling edge, returns at the falling edge after acceptance.
    task automatic send(input logic [CW_W-1:0] w, input string tag);
        while (!cw_ready) @(negedge clk);
        cw_valid = 1'b1;
        cw_data  = w;
        model(w, tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        cw_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        cw_valid = 1'b0;
        cw_data  = '0;
        for (int i = 0; i < WIN_DEPTH; i++) hist.push_back('0);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(cw_ready == 1'b1, "R1 cw_ready after reset", int'(cw_ready), 1);

        // R1 zero history read through a back-reference
        send(mk_ref(5, 2), "R1 zero window");

        // R3 back-to-back literals
        send(mk_lit(8'hA1), "R3 literal");
        send(mk_lit(8'hB2), "R3 literal");
        send(mk_lit(8'hC3), "R3 literal");
        send(mk_lit(8'hD4), "R3 literal");
        send(mk_lit(8'hE5), "R3 literal");
        idle(2);

        // R4 non-overlapping copy, R5 distance
        send(mk_ref(3, 2), "R4 copy run");
        // R5 overlapping copy at the maximum length
        send(mk_ref(0, 7), "R5 overlap repeat");
        send(mk_lit(8'h11), "R3 literal");
        send(mk_lit(8'h22), "R3 literal");
        send(mk_ref(1, 5), "R5 overlap period two");

        // R2 ignored bit in a back-reference
        begin
            logic [CW_W-1:0] w;
            w = mk_ref(2, 1);
            w[CW_W-2] = 1'b1;
            send(w, "R2 spare bit ignored");
        end
        idle(1);

        // R6 ready window length, R7 junk offered while busy
        begin
            int low_cycles;
            send(mk_ref(4, 4), "R6 run");
            low_cycles = 0;
            cw_valid = 1'b1;
            cw_data  = mk_lit(8'h5A);
            while (!cw_ready && low_cycles < 20) begin
                low_cycles++;
                @(negedge clk);
            end
            cw_valid = 1'b0;
            check(low_cycles == 4, "R6 ready low cycles", low_cycles, 4);
            check(cw_ready == 1'b1, "R6 ready restored", int'(cw_ready), 1);
        end
        idle(2);

        // R8 depth: fill with distinct literals then reach the oldest stage
        for (int i = 0; i < 20; i++) send(mk_lit(SYM_W'(8'h40 + i)), "R8 fill");
        send(mk_ref(WIN_DEPTH-1, 0), "R8 oldest stage");
        send(mk_ref(WIN_DEPTH-1, 3), "R8 oldest run");

        // R9 quiet gap
        idle(6);
        send(mk_lit(8'h7E), "R3 literal after gap");
        idle(12);

        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule